// File: doc/BRIEF.md
# Indexed Ready/Valid Channel Router

This block ties one of several ready/valid producer channels to one of several ready/valid consumer channels, picked each cycle by two index inputs. The chosen producer's valid flag and payload are passed forward to the chosen consumer, and that consumer's ready flag is passed back to the chosen producer. Every other producer sees ready held low, and every other consumer sees valid held low. A producer that is not selected therefore never believes a beat was accepted, and a consumer that is not selected never takes a beat.

There are no registers in the path. A beat moves on the consumer's clock edge only when the routed valid and the routed ready are both high in that cycle. An index value at or above the channel count names no channel. In that case the whole fabric goes idle: no ready and no valid is asserted anywhere. Both indices may name the same channel number. The channel count, the payload width and the mux structure are all parameters.

Top module: `channel_router`

## Requirements
- R1: When both indices are below NUM_CH, out_valid bit dst_sel equals in_valid bit src_sel.
- R2: When both indices are below NUM_CH, payload lane dst_sel of out_data equals payload lane src_sel of in_data. Lane k occupies bits k*DATA_W up to k*DATA_W+DATA_W-1, and DATA_W is 8 by default.
- R3: When both indices are below NUM_CH, in_ready bit src_sel equals out_ready bit dst_sel.
- R4: Every in_ready bit other than bit src_sel is 0, whatever out_ready and in_valid hold.
- R5: Every out_valid bit other than bit dst_sel is 0, whatever in_valid and out_ready hold.
- R6: When src_sel or dst_sel is NUM_CH or greater, all in_ready and all out_valid bits are 0. The default NUM_CH is 5 with 3-bit indices, so the values 5, 6 and 7 are out of range.
- R7: The outputs follow input changes within the same cycle and need no clock edge. A change of out_ready shows on in_ready before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_sel | input | IDX_W | Index of the producer channel to route |
| dst_sel | input | IDX_W | Index of the consumer channel to route |
| in_valid | input | NUM_CH | Valid flag from each producer |
| in_data | input | NUM_CH*DATA_W | Payload lanes from the producers, lane k at bit k*DATA_W |
| in_ready | output | NUM_CH | Ready flag returned to each producer |
| out_valid | output | NUM_CH | Valid flag driven to each consumer |
| out_data | output | NUM_CH*DATA_W | Payload lanes to the consumers; every lane carries the routed payload |
| out_ready | input | NUM_CH | Ready flag from each consumer |

## Verification
The block holds no state, so any fault in decoding or muxing shows at the ports in the same cycle as the index values that trigger it. A fault takes one of three forms: a ready raised on a producer that is not selected, a valid raised on a consumer that is not selected, or a routed bit taken from the wrong lane. The bench sweeps every pair of source and destination index values, out-of-range values included, under random and saturated handshake patterns. It compares the full ready and valid vectors with the expected values after each change, so a single wrong bit is caught at the first pattern that exercises it.

// File: rtl/router_pkg.sv
package router_pkg;

   typedef enum logic [0:0] {
      MUX_ONEHOT  = 1'b0,
      MUX_INDEXED = 1'b1
   } mux_style_e;

   function automatic int sel_width(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/router_sel_decode.sv
module router_sel_decode #(
   parameter int NUM_CH = 5,
   parameter int IDX_W  = router_pkg::sel_width(NUM_CH)
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [NUM_CH-1:0] hot
);
   localparam int SPAN = 1 << IDX_W;

   if (NUM_CH > SPAN) begin : g_bad
      $error("router_sel_decode: IDX_W too narrow for NUM_CH");
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_line
      assign hot[i] = (idx == IDX_W'(i));
   end

   always_comb begin
      assert ($onehot0(hot)) else $error("p_hot_onehot_r4 violated");
   end
endmodule

// File: rtl/router_src_mux.sv
module router_src_mux #(
   parameter int                     NUM_CH    = 5,
   parameter int                     DATA_W    = 8,
   parameter int                     IDX_W     = router_pkg::sel_width(NUM_CH),
   parameter router_pkg::mux_style_e MUX_STYLE = router_pkg::MUX_ONEHOT
) (
   input  logic [IDX_W-1:0]         idx,
   input  logic [NUM_CH-1:0]        hot,
   input  logic [NUM_CH-1:0]        lane_valid,
   input  logic [NUM_CH*DATA_W-1:0] lane_data,
   output logic                     pick_valid,
   output logic [DATA_W-1:0]        pick_data
);
   logic [DATA_W-1:0] lanes [NUM_CH];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_split
      assign lanes[i] = lane_data[i*DATA_W +: DATA_W];
   end

   if (MUX_STYLE == router_pkg::MUX_ONEHOT) begin : g_andor
      logic unused_idx;
      assign unused_idx = ^idx;
      always_comb begin
         pick_valid = 1'b0;
         pick_data  = '0;
         for (int i = 0; i < NUM_CH; i++) begin
            pick_valid = pick_valid | (hot[i] & lane_valid[i]);
            pick_data  = pick_data  | ({DATA_W{hot[i]}} & lanes[i]);
         end
      end
   end else begin : g_index
      logic in_range;
      logic unused_hot;
      assign unused_hot = ^hot;
      assign in_range   = ({1'b0, idx} < (IDX_W+1)'(NUM_CH));
      assign pick_valid = in_range ? lane_valid[idx] : 1'b0;
      assign pick_data  = in_range ? lanes[idx] : '0;
   end

   always_comb begin
      assert (!(hot == '0 && pick_valid)) else $error("p_no_src_valid_r6 violated");
   end
endmodule

// File: rtl/channel_router.sv
module channel_router #(
   parameter int                     NUM_CH    = 5,
   parameter int                     DATA_W    = 8,
   parameter router_pkg::mux_style_e MUX_STYLE = router_pkg::MUX_ONEHOT,
   localparam int                    IDX_W     = router_pkg::sel_width(NUM_CH)
) (
   input  logic [IDX_W-1:0]         src_sel,
   input  logic [IDX_W-1:0]         dst_sel,
   input  logic [NUM_CH-1:0]        in_valid,
   input  logic [NUM_CH*DATA_W-1:0] in_data,
   output logic [NUM_CH-1:0]        in_ready,
   output logic [NUM_CH-1:0]        out_valid,
   output logic [NUM_CH*DATA_W-1:0] out_data,
   input  logic [NUM_CH-1:0]        out_ready
);
   if (NUM_CH < 2) begin : g_chk_ch
      $error("channel_router: NUM_CH must be at least 2");
   end
   if (DATA_W < 1) begin : g_chk_w
      $error("channel_router: DATA_W must be at least 1");
   end

   logic [NUM_CH-1:0] src_hot;
   logic [NUM_CH-1:0] dst_hot;
   logic              fwd_valid;
   logic [DATA_W-1:0] fwd_data;
   logic              back_ready;

   router_sel_decode #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_src_dec (
      .idx (src_sel),
      .hot (src_hot)
   );

   router_sel_decode #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_dst_dec (
      .idx (dst_sel),
      .hot (dst_hot)
   );

   router_src_mux #(
      .NUM_CH(NUM_CH), .DATA_W(DATA_W), .IDX_W(IDX_W), .MUX_STYLE(MUX_STYLE)
   ) u_mux (
      .idx        (src_sel),
      .hot        (src_hot),
      .lane_valid (in_valid),
      .lane_data  (in_data),
      .pick_valid (fwd_valid),
      .pick_data  (fwd_data)
   );

   assign back_ready = |(dst_hot & out_ready);
   assign in_ready   = src_hot & {NUM_CH{back_ready}};
   assign out_valid  = dst_hot & {NUM_CH{fwd_valid}};
   assign out_data   = {NUM_CH{fwd_data}};

   logic src_ok;
   logic dst_ok;
   assign src_ok = int'(src_sel) < NUM_CH;
   assign dst_ok = int'(dst_sel) < NUM_CH;

   always_comb begin
      if (src_ok && dst_ok) begin
         p_fwd_valid_r1: assert (out_valid[dst_sel] == in_valid[src_sel]);
         p_fwd_data_r2:  assert (out_data[int'(dst_sel)*DATA_W +: DATA_W]
                                 == in_data[int'(src_sel)*DATA_W +: DATA_W]);
         p_back_ready_r3: assert (in_ready[src_sel] == out_ready[dst_sel]);
      end else begin
         p_bad_idx_r6: assert (in_ready == '0 && out_valid == '0);
      end
      p_idle_ready_r4: assert ($onehot0(in_ready));
      p_idle_valid_r5: assert ($onehot0(out_valid));
      for (int k = 0; k < NUM_CH; k++) begin
         if (k != int'(src_sel)) begin
            p_other_ready_r4: assert (!in_ready[k]);
         end
         if (k != int'(dst_sel)) begin
            p_other_valid_r5: assert (!out_valid[k]);
         end
      end
   end
endmodule

// File: tb/channel_router_test.sv
module channel_router_test;
   localparam int N  = 5;
   localparam int W  = 8;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   logic [IW-1:0]  src_sel, dst_sel;
   logic [N-1:0]   in_valid, in_ready, out_valid, out_ready;
   logic [N*W-1:0] in_data, out_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   channel_router uut (
      .src_sel(src_sel), .dst_sel(dst_sel),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
   );

   function automatic logic [N-1:0] exp_ready(int s, int d, logic [N-1:0] ordy);
      logic [N-1:0] r = '0;
      if (s < N && d < N) r[s] = ordy[d];
      return r;
   endfunction

   function automatic logic [N-1:0] exp_valid(int s, int d, logic [N-1:0] ivld);
      logic [N-1:0] v = '0;
      if (s < N && d < N) v[d] = ivld[s];
      return v;
   endfunction

   task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h (src=%0d dst=%0d)",
                  tag, got, exp, src_sel, dst_sel);
      end
   endtask

   task automatic apply_and_check(int s, int d);
      #1;
      check("R1/R5/R6 out_valid", 64'(out_valid), 64'(exp_valid(s, d, in_valid)));
      check("R3/R4/R6 in_ready",  64'(in_ready),  64'(exp_ready(s, d, out_ready)));
      if (s < N && d < N)
         check("R2 routed payload", 64'(out_data[d*W +: W]), 64'(in_data[s*W +: W]));
   endtask

   initial begin
      int seed = 32'h5eed;
      void'($urandom(seed));
      src_sel = '0; dst_sel = '0;
      in_valid = '0; in_data = '0; out_ready = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      check("reset state in_ready",  64'(in_ready),  64'd0);
      check("reset state out_valid", 64'(out_valid), 64'd0);

      for (int s = 0; s < (1 << IW); s++) begin
         for (int d = 0; d < (1 << IW); d++) begin
            @(negedge clk);
            src_sel = IW'(s); dst_sel = IW'(d);
            in_valid = '1; out_ready = '1;
            for (int k = 0; k < N; k++) in_data[k*W +: W] = W'(8'hA0 + k);
            apply_and_check(s, d);
            for (int r = 0; r < 4; r++) begin
               @(negedge clk);
               in_valid  = N'($urandom);
               out_ready = N'($urandom);
               for (int k = 0; k < N; k++) in_data[k*W +: W] = W'($urandom);
               apply_and_check(s, d);
            end
            // R7: flip consumer ready mid-cycle, no edge in between
            out_ready = ~out_ready;
            apply_and_check(s, d);
         end
      end

      // R4/R5: non-selected lanes fully busy, selected pair idle
      @(negedge clk);
      src_sel = 3'd1; dst_sel = 3'd3;
      in_valid = 5'b11101; out_ready = 5'b10111;
      apply_and_check(1, 3);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end
endmodule